// File: doc/BRIEF.md
# Operation-list I2C master engine

This block is an I2C controller that runs a short list of bus operations from its registers, so software never steps the bus one byte at a time. Software loads a target address, up to sixteen 4-bit operation codes and up to eight bytes of outgoing data. It then sets the run bit. The engine works through the list in order and produces START, address, data and STOP phases on open-drain SCL and SDA. Incoming bytes are collected into two read-data words. Status reports whether a run is in progress and whether a target failed to acknowledge. A one-cycle interrupt marks the end of each run.

The register port is a simple word-addressed write strobe with a combinational read. One word pointer serves both directions. It starts at zero on every run and steps on each data operation. A write then read with a repeated START therefore places the returned byte after the bytes already sent. Bus timing is set by the parameter `QTR`, the number of clock cycles in each quarter of an SCL bit.

Top module: `i2c_oplist_master`

## Requirements
- R1: After reset, every register reads 0, `scl_oe`, `sda_oe` and `irq` are 0, and the engine is idle.
- R2: A run starts only when a write to word 0 takes bit 0 from 0 to 1. Writing 1 while the bit already holds 1 starts nothing and produces no bus activity.
- R3: The list has sixteen 4-bit entries. Entry n for n = 0..7 sits at bits [4n+3:4n] of word 2, and entry n for n = 8..15 sits at bits [4(n-8)+3:4(n-8)] of word 3. Entries run in ascending order.
- R4: The operation codes are: 1 issues a START or repeated START; 2 sends {target[7:1],0}; 3 sends {target[7:1],1}; 4 moves a data byte; 5 moves the final data byte; 6 issues a STOP; 0 ends the list. Codes 7 to 15 are skipped and cause no bus activity.
- R5: Outgoing bytes are little-endian. Byte k sits in bits [8k+7:8k] of word 4 for k < 4, and in bits [8(k-4)+7:8(k-4)] of word 5 for k = 4..7. Each data operation uses the byte at the shared pointer, which is 0 at the start of each run.
- R6: In read direction (after code 3), each data operation stores the received byte at the shared pointer position, using the same layout in words 6 and 7. Code 4 answers with ACK (SDA low in the ninth clock) and code 5 answers with NAK.
- R7: Word 0 bit 2 reads 1 from the cycle after a run starts until the run finishes, then reads 0.
- R8: If word 0 bit 1 is clear and the target leaves SDA high in the ninth clock after an address byte or a written byte, word 0 bit 3 becomes 1. The engine then issues a STOP, ends the run and skips the rest of the list. Bit 3 is cleared when the next run starts.
- R9: If word 0 bit 1 is set, a missing acknowledge has no effect: the list runs on and bit 3 stays 0.
- R10: A run ends at the first code 0 or after entry 15. Both normal completion and error completion pulse `irq` high for exactly one cycle.
- R11: Writing 0 to word 0 bit 0 during a run aborts it. Bit 2 drops, both lines are released on the next cycle, and no interrupt is raised.
- R12: Both lines are open-drain, and an output enable of 1 pulls the line low. SDA changes while SCL is released only to form a START (SDA falling) or a STOP (SDA rising). The acknowledge is sampled while SCL is high in the ninth clock.
- R13: Word 1 holds the 8-bit target field (address shifted left by one). Words 1 to 5 read back what was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | One-cycle pulse when a run ends |

## Verification
Each kind of internal fault shows up at the ports in a different place and at a different time:
- A list index or pointer that is off by one shows up within one byte time (36 quarters). The wrong byte reaches the bus model, a read byte lands in the wrong word position, or the START and STOP counts differ from what the list encodes.
- A wrong acknowledge decision shows up as a stuck or stray error bit. It can also show as a missing STOP, which is seen at the end of the run.
- A busy flag or bus enable left set after completion or abort is seen on the very next clock. The bench's per-clock model expects released lines and a quiet interrupt whenever no run is outstanding.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  localparam int OPW    = 4;
  localparam int LIST_N = 16;
  localparam int IDXW   = $clog2(LIST_N) + 1;
  localparam int BUF_N  = 8;
  localparam int PTRW   = $clog2(BUF_N);
  localparam int LISTB  = LIST_N * OPW;
  localparam int BUFB   = BUF_N * 8;

  localparam logic [OPW-1:0] OP_END    = 4'd0;
  localparam logic [OPW-1:0] OP_START  = 4'd1;
  localparam logic [OPW-1:0] OP_ADDR_W = 4'd2;
  localparam logic [OPW-1:0] OP_ADDR_R = 4'd3;
  localparam logic [OPW-1:0] OP_DATA   = 4'd4;
  localparam logic [OPW-1:0] OP_LAST   = 4'd5;
  localparam logic [OPW-1:0] OP_STOP   = 4'd6;

  typedef enum logic [1:0] {PC_IDLE, PC_START, PC_STOP, PC_BYTE} phy_cmd_e;
  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_WAIT, W_NAKSTOP} walk_e;

  function automatic logic op_is_data(logic [OPW-1:0] op);
    return (op == OP_DATA) || (op == OP_LAST);
  endfunction

  // target must answer the ninth clock for addresses and written bytes
  function automatic logic op_wants_ack(logic [OPW-1:0] op, logic rd);
    return (op == OP_ADDR_W) || (op == OP_ADDR_R) || (op_is_data(op) && !rd);
  endfunction

  // 1 = pull SDA low during bit 'bitn' of a byte slot (bit 8 = acknowledge)
  function automatic logic byte_pull(logic [3:0] bitn, logic msb, logic rd, logic nak_reply);
    if (bitn < 4'd8) return rd ? 1'b0 : !msb;
    return rd ? !nak_reply : 1'b0;
  endfunction
endpackage

// File: rtl/i2cseq_phy.sv
module i2cseq_phy
  import i2cseq_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     go,
  input  phy_cmd_e cmd,
  input  logic [7:0] tx,
  input  logic     rd,
  input  logic     nak_reply,
  input  logic     abort,
  input  logic     sda_in,
  output logic     done,
  output logic [7:0] rx,
  output logic     nak,
  output logic     scl_oe,
  output logic     sda_oe
);
  localparam int DW = (QTR > 1) ? $clog2(QTR) : 1;

  phy_cmd_e   st;
  logic [DW-1:0] div;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       rbit, line_low, rd_q, nakr_q;

  wire qend    = (div == DW'(QTR - 1));
  wire bit_end = qend && (q == 2'd3);

  always_comb begin
    scl_oe = line_low;
    sda_oe = 1'b0;
    unique case (st)
      PC_START: begin scl_oe = (q == 2'd0) ? line_low : (q == 2'd3); sda_oe = q[1]; end
      PC_STOP:  begin scl_oe = (q == 2'd0); sda_oe = !q[1]; end
      PC_BYTE:  begin scl_oe = !q[1]; sda_oe = byte_pull(bitn, sh[7], rd_q, nakr_q); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PC_IDLE; div <= '0; q <= '0; bitn <= '0; sh <= '0;
      rbit <= 1'b0; line_low <= 1'b0; rd_q <= 1'b0; nakr_q <= 1'b0;
      done <= 1'b0; rx <= '0; nak <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        st <= PC_IDLE; line_low <= 1'b0;
      end else if (st == PC_IDLE) begin
        if (go) begin
          st <= cmd; div <= '0; q <= '0; bitn <= '0;
          sh <= tx; rd_q <= rd; nakr_q <= nak_reply;
        end
      end else begin
        div <= qend ? '0 : div + 1'b1;
        if (qend) q <= q + 1'b1;
        if (qend && q == 2'd2) rbit <= sda_in;
        if (bit_end) begin
          if (st != PC_BYTE) begin
            st <= PC_IDLE; done <= 1'b1; line_low <= (st == PC_START);
          end else if (bitn == 4'd8) begin
            st <= PC_IDLE; done <= 1'b1; nak <= rbit; rx <= sh; line_low <= 1'b1;
          end else begin
            sh <= {sh[6:0], rbit}; bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  // R12: SDA may not move while SCL is released inside a byte slot
  p_sda_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PC_BYTE && q == 2'd3 && $past(st) == PC_BYTE) |-> $stable(sda_oe));
  // R12: a START always ends with SCL pulled low
  p_start_ends_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st) == PC_START) |-> scl_oe);
  // R10: completion of a primitive is a single-cycle event
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/i2c_oplist_master.sv
module i2c_oplist_master
  import i2cseq_pkg::*;
#(
  parameter int QTR = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq
);
  logic            go_q, ackign_q, err_q, busy_q, dir_rd;
  logic [7:0]      tgt_q;
  logic [LISTB-1:0] list_q;
  logic [BUFB-1:0] wbuf_q, rbuf_q;
  logic [IDXW-1:0] idx;
  logic [PTRW-1:0] ptr;
  logic [OPW-1:0]  op_q;
  walk_e           wst;

  phy_cmd_e   pcmd;
  logic [7:0] ptx;
  logic       pgo, prd, pnak;
  logic       phy_done, phy_nak;
  logic [7:0] phy_rx;

  // named events for the assertions
  wire ctrl_wr   = reg_wr && (reg_addr == 3'd0);
  wire start_evt = ctrl_wr && reg_wdata[0] && !go_q && !busy_q;
  wire abort_evt = ctrl_wr && !reg_wdata[0] && busy_q;
  wire [OPW-1:0] cur = list_q[{idx[IDXW-2:0], 2'b00} +: OPW];
  wire list_done = (idx == IDXW'(LIST_N)) || (cur == OP_END);

  always_comb begin
    unique case (reg_addr)
      3'd0: reg_rdata = {28'd0, err_q, busy_q, ackign_q, go_q};
      3'd1: reg_rdata = {24'd0, tgt_q};
      3'd2: reg_rdata = list_q[31:0];
      3'd3: reg_rdata = list_q[63:32];
      3'd4: reg_rdata = wbuf_q[31:0];
      3'd5: reg_rdata = wbuf_q[63:32];
      3'd6: reg_rdata = rbuf_q[31:0];
      default: reg_rdata = rbuf_q[63:32];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; ackign_q <= 1'b0; err_q <= 1'b0; busy_q <= 1'b0; dir_rd <= 1'b0;
      tgt_q <= '0; list_q <= '0; wbuf_q <= '0; rbuf_q <= '0;
      idx <= '0; ptr <= '0; op_q <= '0; wst <= W_IDLE; irq <= 1'b0;
      pcmd <= PC_IDLE; ptx <= '0; pgo <= 1'b0; prd <= 1'b0; pnak <= 1'b0;
    end else begin
      pgo <= 1'b0;
      irq <= 1'b0;
      if (reg_wr) begin
        unique case (reg_addr)
          3'd0: begin go_q <= reg_wdata[0]; ackign_q <= reg_wdata[1]; end
          3'd1: tgt_q <= reg_wdata[7:0];
          3'd2: list_q[31:0] <= reg_wdata;
          3'd3: list_q[63:32] <= reg_wdata;
          3'd4: wbuf_q[31:0] <= reg_wdata;
          3'd5: wbuf_q[63:32] <= reg_wdata;
          default: ;
        endcase
      end
      if (abort_evt) begin
        busy_q <= 1'b0; wst <= W_IDLE;
      end else if (start_evt) begin
        busy_q <= 1'b1; err_q <= 1'b0; idx <= '0; ptr <= '0; dir_rd <= 1'b0; wst <= W_FETCH;
      end else begin
        unique case (wst)
          W_FETCH: begin
            if (list_done) begin
              busy_q <= 1'b0; irq <= 1'b1; wst <= W_IDLE;
            end else if (cur > OP_STOP) begin
              idx <= idx + 1'b1;
            end else begin
              pgo <= 1'b1; op_q <= cur; wst <= W_WAIT;
              prd <= 1'b0; pnak <= 1'b0; ptx <= wbuf_q[{ptr, 3'b000} +: 8];
              unique case (cur)
                OP_START: pcmd <= PC_START;
                OP_STOP:  pcmd <= PC_STOP;
                OP_ADDR_W, OP_ADDR_R: begin
                  pcmd <= PC_BYTE; ptx <= {tgt_q[7:1], cur == OP_ADDR_R};
                  dir_rd <= (cur == OP_ADDR_R);
                end
                default: begin pcmd <= PC_BYTE; prd <= dir_rd; pnak <= (cur == OP_LAST); end
              endcase
            end
          end
          W_WAIT: if (phy_done) begin
            if (op_is_data(op_q)) begin
              ptr <= ptr + 1'b1;
              if (dir_rd) rbuf_q[{ptr, 3'b000} +: 8] <= phy_rx;
            end
            if (phy_nak && !ackign_q && op_wants_ack(op_q, dir_rd)) begin
              err_q <= 1'b1; pgo <= 1'b1; pcmd <= PC_STOP; wst <= W_NAKSTOP;
            end else begin
              idx <= idx + 1'b1; wst <= W_FETCH;
            end
          end
          W_NAKSTOP: if (phy_done) begin busy_q <= 1'b0; irq <= 1'b1; wst <= W_IDLE; end
          default: ;
        endcase
      end
    end
  end

  i2cseq_phy #(.QTR(QTR)) u_phy (
    .clk(clk), .rst_n(rst_n), .go(pgo), .cmd(pcmd), .tx(ptx), .rd(prd),
    .nak_reply(pnak), .abort(abort_evt), .sda_in(sda_in), .done(phy_done),
    .rx(phy_rx), .nak(phy_nak), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  p_idle_at_irq_r7: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !busy_q);
  p_abort_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!scl_oe && !sda_oe && !irq && !busy_q));
  p_run_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (go_q && !$past(go_q)));
  p_err_then_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wst == W_NAKSTOP) |-> (err_q && busy_q));
endmodule

// File: tb/sim_i2c_oplist_master.sv
module sim_i2c_oplist_master;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic scl_oe, sda_oe, irq, sda_in;
  logic s_drv;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_drv);
  assign sda_in = sda_line;

  i2c_oplist_master #(.QTR(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  // behavioural target on the bus
  logic pscl = 1'b1, psda = 1'b1, ackbit = 1'b1;
  logic [7:0] sh = 8'd0, txb = 8'd0, last_addr = 8'd0;
  int bitc = 0, phase = 0, rcnt = 0, starts = 0, stops = 0;
  logic [7:0] wq[$];
  logic mack[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_drv <= 1'b0; pscl <= 1'b1; psda <= 1'b1; bitc = 0; phase = 0;
    end else begin
      pscl <= scl_line; psda <= sda_line;
      if (pscl && scl_line && psda && !sda_line) begin
        starts++; bitc = 0; phase = 1; s_drv <= 1'b0;
      end else if (pscl && scl_line && !psda && sda_line) begin
        stops++; bitc = 0; phase = 0; s_drv <= 1'b0;
      end else if (!pscl && scl_line) begin
        if (bitc < 8) begin sh = {sh[6:0], sda_line}; bitc++; end
        else begin ackbit = sda_line; bitc = 9; if (phase == 4) mack.push_back(ackbit); end
      end else if (pscl && !scl_line) begin
        if (bitc == 8) begin
          if (phase == 1) begin
            last_addr = sh;
            if (sh[7:1] == SLV) begin s_drv <= 1'b1; phase = sh[0] ? 3 : 2; rcnt = 0; end
            else begin s_drv <= 1'b0; phase = 0; end
          end else if (phase == 2) begin wq.push_back(sh); s_drv <= 1'b1; end
          else s_drv <= 1'b0;
        end else if (bitc == 9) begin
          bitc = 0;
          if (phase == 3 || (phase == 4 && !ackbit)) begin
            txb = 8'hA0 + 8'(rcnt); rcnt++; phase = 4; s_drv <= !txb[7];
          end else begin
            s_drv <= 1'b0; if (phase == 4) phase = 0;
          end
        end else if (phase == 4 && bitc >= 1 && bitc <= 7) begin
          s_drv <= !txb[7 - bitc];
        end
      end
    end
  end

  // per-clock reference: no run outstanding -> lines released, irq quiet; irq one cycle
  logic mdl_run = 1'b0, prev_irq = 1'b0;
  int mon_bad = 0, irq_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mdl_run && (scl_oe || sda_oe || irq)) begin
        mon_bad++;
        if (mon_bad < 4) $display("FAIL R10/R11 monitor: scl_oe=%b sda_oe=%b irq=%b exp 0 0 0", scl_oe, sda_oe, irq);
      end
      if (irq && prev_irq) begin
        mon_bad++;
        $display("FAIL R10 irq high two cycles act=1 exp=0");
      end
      prev_irq = irq;
      if (irq) begin irq_seen++; mdl_run = 1'b0; end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic run(input logic ign, output int got_irq);
    int n0;
    n0 = irq_seen;
    wr(3'd0, {30'd0, ign, 1'b0});
    mdl_run = 1'b1;
    wr(3'd0, {30'd0, ign, 1'b1});
    got_irq = 0;
    for (int i = 0; i < 20000 && got_irq == 0; i++) begin
      @(negedge clk); #1;
      if (irq_seen != n0) got_irq = 1;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] t, input logic [31:0] l0, input logic [31:0] l1,
                       input logic [31:0] w0, input logic [31:0] w1);
    wr(3'd1, {24'd0, t}); wr(3'd2, l0); wr(3'd3, l1); wr(3'd4, w0); wr(3'd5, w1);
    wq.delete(); mack.delete();
  endtask

  initial begin
    logic [31:0] v;
    int g, s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ctrl reset", v, 32'd0);
    rd(3'd6, v); chk("R1 read data reset", v, 32'd0);
    chk("R1 lines/irq reset", {29'd0, scl_oe, sda_oe, irq}, 32'd0);

    // three-byte write
    setup(8'h54, 32'h00644421, 32'd0, 32'h00332211, 32'd0);
    rd(3'd2, v); chk("R13 list lo readback", v, 32'h00644421);
    rd(3'd1, v); chk("R13 target readback", v, 32'h54);
    s0 = starts; p0 = stops;
    wr(3'd0, 32'd0); mdl_run = 1'b1; wr(3'd0, 32'd1);
    rd(3'd0, v); chk("R7 busy during run", 32'(v[2]), 32'd1);
    g = 0;
    for (int i = 0; i < 20000 && mdl_run; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 irq at completion", 32'(mdl_run), 32'd0);
    rd(3'd0, v); chk("R7 busy cleared, no error", v, 32'h1);
    chk("R4 address byte", 32'(last_addr), 32'h54);
    chk("R5 write bytes", {8'(wq.size()), wq.size() > 2 ? {wq[0], wq[1], wq[2]} : 24'd0}, {8'd3, 24'h112233});
    chk("R12 start/stop count", {16'(starts - s0), 16'(stops - p0)}, {16'd1, 16'd1});

    // R2: rewriting 1 does nothing
    s0 = starts; g = irq_seen;
    wr(3'd0, 32'd1);
    repeat (200) @(negedge clk);
    rd(3'd0, v);
    chk("R2 no run on level", {16'(starts - s0), 8'(irq_seen - g), 8'(v[2])}, 32'd0);

    // eight-byte write, entries beyond 7 in the second list word
    setup(8'h54, 32'h44444421, 32'h00000644, 32'h44332211, 32'h88776655);
    run(1'b0, g);
    chk("R3 eight-byte run completed", 32'(g), 32'd1);
    chk("R5 byte count", 32'(wq.size()), 32'd8);
    if (wq.size() == 8) begin
      chk("R5 bytes 0-3", {wq[0], wq[1], wq[2], wq[3]}, 32'h11223344);
      chk("R5 bytes 4-7", {wq[4], wq[5], wq[6], wq[7]}, 32'h55667788);
    end

    // three-byte read
    setup(8'h54, 32'h00654431, 32'd0, 32'd0, 32'd0);
    run(1'b0, g);
    chk("R4 read address byte", 32'(last_addr), 32'h55);
    rd(3'd6, v); chk("R6 read data layout", v, 32'h00A2A1A0);
    chk("R6 ack/ack/nak", {29'd0, mack.size() == 3 ? {mack[0], mack[1], mack[2]} : 3'b111}, 32'b001);

    // write then repeated start read: shared pointer
    s0 = starts; p0 = stops;
    setup(8'h54, 32'h06531421, 32'd0, 32'h0000005A, 32'd0);
    run(1'b0, g);
    chk("R5 combined write byte", {8'(wq.size()), wq.size() > 0 ? wq[0] : 8'd0}, {8'd1, 8'h5A});
    rd(3'd6, v); chk("R5/R6 pointer shared", v, 32'h00A2A0A0);
    chk("R4 repeated start", {16'(starts - s0), 16'(stops - p0)}, {16'd2, 16'd1});

    // NAK on address
    s0 = starts; p0 = stops;
    setup(8'h66, 32'h00644421, 32'd0, 32'h00332211, 32'd0);
    run(1'b0, g);
    chk("R8 irq on error", 32'(g), 32'd1);
    rd(3'd0, v); chk("R8 error bit", v, 32'h9);
    chk("R8 stop issued", {16'(starts - s0), 16'(stops - p0)}, {16'd1, 16'd1});

    // NAK ignored
    s0 = starts; p0 = stops;
    run(1'b1, g);
    rd(3'd0, v); chk("R9 no error when ignoring", v, 32'h3);
    chk("R9 list ran to stop", {16'(starts - s0), 16'(stops - p0)}, {16'd1, 16'd1});

    // sixteen entries with skipped codes, STOP in entry 15
    p0 = stops;
    setup(8'h54, 32'hFFFFF421, 32'h6FFFFFFF, 32'h000000C3, 32'd0);
    run(1'b0, g);
    chk("R10 stops after entry 15", 32'(g), 32'd1);
    chk("R4 skipped codes", {8'(wq.size()), wq.size() > 0 ? wq[0] : 8'd0, 16'(stops - p0)}, {8'd1, 8'hC3, 16'd1});

    // abort mid-run
    setup(8'h54, 32'h00644421, 32'd0, 32'h00332211, 32'd0);
    g = irq_seen;
    wr(3'd0, 32'd0); mdl_run = 1'b1; wr(3'd0, 32'd1);
    repeat (200) @(negedge clk);
    wr(3'd0, 32'd0);
    mdl_run = 1'b0;
    #1 chk("R11 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    rd(3'd0, v); chk("R11 busy dropped", v, 32'd0);
    repeat (400) @(negedge clk);
    chk("R11 no irq after abort", 32'(irq_seen - g), 32'd0);

    chk("R12 per-clock monitor", 32'(mon_bad), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule